// File: doc/BRIEF.md
# Dual Cache-Set Context Switcher

This controller sits between a processor pipeline and two complete cache sets. Each set holds a stack cache, a data cache and an instruction cache, and each belongs to one of two resident processes. Only one set serves requests at a time. When the running process hits a switch event, the controller decides whether the other process can take over. A switch is a short register swap during which the pipeline stalls. After the swap, the set that was just left gets its flush and reload work in the background while the other process runs.

Each cache type is told to flush through its own one-cycle start line. The instruction cache only invalidates. The stack cache starts a block-aligned write-back and resets its two wrap pointers. The data cache drains its delayed writes. The engines that do this work sit outside the block and report back on separate done lines, so each cache type can take as long as it needs. A set becomes eligible again only when all three of its done lines have reported and its process is ready. If a switch event arrives while the other set is not eligible, the processor idles until it is. Synchronising operations such as test-and-set skip both cache sets and go to main memory.

Top module: `dual_set_switcher`

## Requirements
- R1: After reset, set 0 is active (`active_set`=0), `stall` and `cpu_idle` are low, no flush line is high, and both sets are eligible.
- R2: While running, a request with `req_valid`=1 and `req_sync`=0 drives `set_req` to the one-hot code of the active set (bit 0 = set 0, bit 1 = set 1) and keeps `mem_req` low. No request reaches either set or memory while `stall` is high.
- R3: A request with `req_valid`=1 and `req_sync`=1 drives `mem_req` high and leaves `set_req` at zero.
- R4: Any single bit of `trig` works as a switch event: bit 0 is timeslice expiry, bit 1 is stack cache exhausted, bit 2 is instruction cache exhausted, bit 3 is a data fetch stalled on an unavailable page.
- R5: When a switch event is sampled and the other set is eligible, `stall` is high for exactly 4 cycles with `cpu_idle` low. `active_set` then inverts and `stall` falls in the same cycle.
- R6: In the cycle the active set changes, `ic_inval`, `sc_flush` and `dc_drain` each pulse for one cycle on the bit of the set just left, and never on the bit of the new active set.
- R7: A set is eligible only when its `ic_done`, `sc_done` and `dc_done` bits have all been seen since its last flush pulse, in any order, and its `proc_ready` bit is high.
- R8: A switch event sampled while the other set is not eligible makes both `cpu_idle` and `stall` high. The swap starts at the first clock edge at which the other set is eligible.
- R9: Done bits reported for the active set are ignored, and `trig` is ignored during the swap and while idling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 4 | Switch events from the active process |
| proc_ready | input | 2 | Per-set flag that its process is ready to run |
| req_valid | input | 1 | Pipeline memory request |
| req_sync | input | 1 | Request is a synchronising operation |
| ic_done | input | 2 | Per-set instruction cache invalidation done |
| sc_done | input | 2 | Per-set stack cache write-back done |
| dc_done | input | 2 | Per-set data cache drain done |
| active_set | output | 1 | Set that serves cached requests |
| stall | output | 1 | Pipeline held (swap or idle) |
| cpu_idle | output | 1 | Waiting for the other set to become eligible |
| set_req | output | 2 | Request routed to a cache set |
| mem_req | output | 1 | Request routed straight to main memory |
| ic_inval | output | 2 | Per-set instruction cache invalidate pulse |
| sc_flush | output | 2 | Per-set stack write-back start and pointer reset pulse |
| dc_drain | output | 2 | Per-set data cache drain start pulse |

## Verification
The main sweep walks every subset of the three done lines that could arrive before a switch event, and cycles through each trigger bit. The full subset shows that the swap starts at once. Each partial subset shows that the block idles and that the swap begins only after the missing completions come in. A second pattern holds back `proc_ready` with every flush complete, which separates the process-readiness condition from flush completion. Done lines pulsed for the active set, and triggers injected during the swap and the idle wait, confirm that neither moves the block. A routing sweep over both request flags, taken with each set active and during a stall, distinguishes cached, bypassed and blocked requests.

// File: rtl/dual_set_switcher.sv
module dual_set_switcher #(
  parameter int SWAP_CYCLES = 4,
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig,
  input  logic [1:0]       proc_ready,
  input  logic             req_valid,
  input  logic             req_sync,
  input  logic [1:0]       ic_done,
  input  logic [1:0]       sc_done,
  input  logic [1:0]       dc_done,
  output logic             active_set,
  output logic             stall,
  output logic             cpu_idle,
  output logic [1:0]       set_req,
  output logic             mem_req,
  output logic [1:0]       ic_inval,
  output logic [1:0]       sc_flush,
  output logic [1:0]       dc_drain
);
  localparam int CW = (SWAP_CYCLES > 1) ? $clog2(SWAP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SWAP_CYCLES - 1);

  typedef enum logic [1:0] {RUN, SWAP, WAIT} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0][2:0] pend;
  logic [1:0] fl;
  logic other, other_ok, running;

  assign other    = ~active_set;
  assign other_ok = (pend[other] == 3'b000) && proc_ready[other];
  assign running  = (st == RUN);
  assign stall    = ~running;
  assign cpu_idle = (st == WAIT);
  assign mem_req  = running & req_valid & req_sync;
  assign set_req  = (running & req_valid & ~req_sync) ? (active_set ? 2'b10 : 2'b01) : 2'b00;
  assign ic_inval = fl;
  assign sc_flush = fl;
  assign dc_drain = fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RUN;
      cnt <= '0;
      active_set <= 1'b0;
      pend <= '0;
      fl <= '0;
    end else begin
      fl <= '0;
      pend[other] <= pend[other] & ~{dc_done[other], sc_done[other], ic_done[other]};
      case (st)
        RUN: if (|trig) begin
          cnt <= '0;
          st <= other_ok ? SWAP : WAIT;
        end
        WAIT: if (other_ok) begin
          cnt <= '0;
          st <= SWAP;
        end
        default: if (cnt == LAST) begin
          st <= RUN;
          active_set <= other;
          fl[active_set] <= 1'b1;
          pend[active_set] <= 3'b111;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R2 R3: at most one destination per request
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_req, mem_req}));
  // R2: nothing is routed while stalled
  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (set_req == 2'b00 && !mem_req));
  // R5: a swap always lasts the full stall window
  a_r5_swap_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> ($past(stall, 1) && $past(stall, 2) && $past(stall, 3) && $past(stall, 4)));
  // R6: flush pulses go only to the set just left
  a_r6_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_inval != 2'b00) |-> (ic_inval[active_set] == 1'b0 && $onehot(ic_inval)));
  // R6: a change of active set comes with its flush pulse
  a_r6_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (active_set != $past(active_set)) |-> (sc_flush[$past(active_set)] && dc_drain[$past(active_set)]));
  // R8: an event with no eligible partner leads to idling
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (|trig) && !other_ok) |=> cpu_idle);
endmodule

// File: tb/test_dual_set_switcher.sv
module test_dual_set_switcher;
  logic clk = 0, rst_n = 0;
  logic [3:0] trig = 0;
  logic [1:0] proc_ready = 2'b11, ic_done = 0, sc_done = 0, dc_done = 0;
  logic req_valid = 0, req_sync = 0;
  logic active_set, stall, cpu_idle, mem_req;
  logic [1:0] set_req, ic_inval, sc_flush, dc_drain;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dual_set_switcher i_dual_set_switcher (
    .clk(clk), .rst_n(rst_n), .trig(trig), .proc_ready(proc_ready),
    .req_valid(req_valid), .req_sync(req_sync),
    .ic_done(ic_done), .sc_done(sc_done), .dc_done(dc_done),
    .active_set(active_set), .stall(stall), .cpu_idle(cpu_idle),
    .set_req(set_req), .mem_req(mem_req),
    .ic_inval(ic_inval), .sc_flush(sc_flush), .dc_drain(dc_drain));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic route_sweep();
    for (int v = 0; v < 4; v++) begin
      req_valid = v[0]; req_sync = v[1];
      #1;
      chk(set_req == ((v[0] && !v[1] && !stall) ? (active_set ? 2 : 1) : 0), "R2", set_req, 0);
      chk(mem_req == (v[0] && v[1] && !stall), "R3", mem_req, v[0] && v[1]);
    end
    req_valid = 0; req_sync = 0;
  endtask

  // Called right after a trigger (or readiness) is applied at a negedge.
  task automatic expect_swap(input logic old);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) trig = 0;
      chk(stall && !cpu_idle, "R5", {stall, cpu_idle}, 2);
      chk(active_set == old, "R5", active_set, old);
      if (k == 1) begin
        trig = 4'hF;
        route_sweep();
      end
      if (k == 2) trig = 0;
    end
    @(negedge clk);
    chk(!stall && active_set == !old, "R5", {stall, active_set}, !old);
    chk(ic_inval == (2'b01 << old) && sc_flush == (2'b01 << old) && dc_drain == (2'b01 << old),
        "R6", {ic_inval, sc_flush, dc_drain}, (2'b01 << old));
    @(negedge clk);
    chk(!stall && ic_inval == 0 && sc_flush == 0 && dc_drain == 0, "R9", {stall, ic_inval}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(active_set == 0 && !stall && !cpu_idle, "R1", {active_set, stall, cpu_idle}, 0);
    chk(ic_inval == 0 && sc_flush == 0 && dc_drain == 0, "R1", ic_inval, 0);
    route_sweep();
    trig = 4'b0001;
    expect_swap(1'b0);
    route_sweep();
    for (int m = 0; m < 16; m++) begin
      logic [2:0] mask;
      a = active_set;
      mask = m[2:0];
      // done for the active set must not make the other set eligible (R9)
      ic_done[a] = 1; sc_done[a] = 1; dc_done[a] = 1;
      @(negedge clk);
      ic_done = 0; sc_done = 0; dc_done = 0;
      for (int b = 0; b < 3; b++) if (mask[b]) begin
        if (b == 0) ic_done[!a] = 1;
        if (b == 1) sc_done[!a] = 1;
        if (b == 2) dc_done[!a] = 1;
        @(negedge clk);
        ic_done = 0; sc_done = 0; dc_done = 0;
      end
      trig = 4'b0001 << (m % 4);
      if (mask == 3'b111) begin
        expect_swap(a);  // R4 R7
      end else begin
        @(negedge clk);
        trig = 0;
        chk(cpu_idle && stall, "R8", {cpu_idle, stall}, 3);
        trig = 4'hF;
        @(negedge clk);
        trig = 0;
        chk(cpu_idle && active_set == a, "R9", {cpu_idle, active_set}, {1'b1, a});
        ic_done[!a] = !mask[0]; sc_done[!a] = !mask[1]; dc_done[!a] = !mask[2];
        @(negedge clk);
        ic_done = 0; sc_done = 0; dc_done = 0;
        chk(cpu_idle, "R7", cpu_idle, 1);
        expect_swap(a);  // R8 first eligible cycle
      end
    end
    a = active_set;
    ic_done[!a] = 1; sc_done[!a] = 1; dc_done[!a] = 1;
    proc_ready[!a] = 0;
    @(negedge clk);
    ic_done = 0; sc_done = 0; dc_done = 0;
    trig = 4'b1000;
    @(negedge clk);
    trig = 0;
    repeat (5) begin
      chk(cpu_idle && stall, "R7", {cpu_idle, stall}, 3);
      @(negedge clk);
    end
    proc_ready[!a] = 1;
    expect_swap(a);  // R8
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule